// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a virtual address into a physical address. It walks a four-level radix tree of translation entries that is held in memory. A caller hands it one virtual address over a valid/ready request channel. The walker takes the physical base of the top directory from a configuration input. It then issues one memory read per level over a valid/ready read port. Each read address is built from the entry returned by the read before it, so the reads form a strictly serial chain. The walker holds at most one read outstanding.

Each level consumes a 9-bit slice of the virtual address and selects one of 512 eight-byte entries. The low 12 bits of the virtual address are a page offset that passes through untranslated. A present leaf at the bottom level yields the page frame and two permission bits. An entry with its present bit clear, at any level, ends the walk at once with a fault that reports the level.

Every channel follows the usual valid/ready rules. A producer that raises valid keeps it high, and keeps its payload unchanged, until the cycle in which ready is also high. The caller may hold off the response with `rsp_ready_i` low. The memory may stall the read request or return data after any number of cycles. The walker accepts a new translation only while it is idle.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy_o`, `mem_req_valid_o` and `rsp_valid_o` are 0 and `req_ready_o` is 1.
- R2: `req_ready_o` is 1 only while no walk is in progress. `busy_o` is 1 from the cycle after a request is accepted until the response handshake. Requests offered while busy are ignored.
- R3: The first read address is `root_base_i` plus 8 times vaddr[47:39].
- R4: Each later read address is the base field of the previous entry, with 12 zero bits appended, plus 8 times the index for that level. The indices are vaddr[38:30], vaddr[29:21] and vaddr[20:12], in that order. A new read is requested only after the previous read's data has been accepted.
- R5: Entry format: bit 0 is present, bit 1 is write, bit 2 is user, and bits 51:12 hold the next-directory base or the leaf frame. Bits 63:52 and 11:3 have no effect.
- R6: When the level-1 entry is present, the response carries `rsp_fault_o`=0, `rsp_level_o`=0, `rsp_paddr_o` = {frame, vaddr[11:0]} and `rsp_perm_o` = {user, write}, after exactly four reads.
- R7: A non-present entry read at level L (4 = root, 1 = leaf) ends the walk with no further read. The response has `rsp_fault_o`=1, `rsp_level_o`=L-1, and `rsp_paddr_o` and `rsp_perm_o` equal to 0.
- R8: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and its address does not change.
- R9: `mem_rsp_ready_o` is 1 exactly while a read is outstanding. Any response latency is accepted.
- R10: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response stays valid and its fields do not change.
- R11: A read request is valid in the cycle after the translation request is accepted, and again in the cycle after each non-final read response. `rsp_valid_o` rises in the cycle after the final read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base_i | input | 52 | Physical base of the top-level directory |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 48 | Virtual address to translate |
| busy_o | output | 1 | A walk is in progress |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Caller accepts the result |
| rsp_paddr_o | output | 52 | Physical address (0 on fault) |
| rsp_perm_o | output | 2 | {user, write} from the leaf (0 on fault) |
| rsp_fault_o | output | 1 | Walk hit a non-present entry |
| rsp_level_o | output | 2 | Faulting level minus one (0 on success) |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 52 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker accepts read data |
| mem_rsp_data_i | input | 64 | Entry returned by memory |

## Verification
Every result has a fixed due cycle, counted from a handshake edge. The first read request is due one cycle after the translation request is accepted. Each later read is due one cycle after the previous read response is accepted. The result is due one cycle after the final read response. The bench drives all inputs and samples all outputs on the falling edge. It checks each read address, and the absence of any other request, at exactly those cycles. It inserts request stalls, response latencies of zero to two cycles, and result back-pressure, and confirms in each waiting cycle that the held values do not move.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2,
    WK_RESP  = 2'd3
  } walk_state_e;

  localparam int unsigned PTE_PRESENT_BIT = 0;
  localparam int unsigned PTE_WRITE_BIT   = 1;
  localparam int unsigned PTE_USER_BIT    = 2;
endpackage

// File: rtl/ptw_idx_addr.sv
module ptw_idx_addr #(
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 52,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned VA_W   = OFF_W + LEVELS * IDX_W,
  localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int unsigned ENT_SH = $clog2(ENTRY_W / 8)
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PA_W-1:0]  dir_base,
  output logic [PA_W-1:0]  entry_addr
);
  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  // One index slice per level; level 0 sits just above the page offset.
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_arr[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
  end

  assign idx_sel    = idx_arr[lvl];
  assign entry_addr = dir_base + PA_W'({idx_sel, {ENT_SH{1'b0}}});
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int unsigned ENTRY_W = 64,
  parameter int unsigned PA_W    = 52,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned PFN_W  = PA_W - OFF_W
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic               present,
  output logic               wr_ok,
  output logic               usr_ok,
  output logic [PFN_W-1:0]   pfn
);
  import ptw_pkg::*;

  logic unused_fields;

  assign present = entry[PTE_PRESENT_BIT];
  assign wr_ok   = entry[PTE_WRITE_BIT];
  assign usr_ok  = entry[PTE_USER_BIT];
  assign pfn     = entry[PA_W-1:OFF_W];

  // Reserved and software bits take no part in the walk.
  assign unused_fields = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:PTE_USER_BIT+1]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 52,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned VA_W   = OFF_W + LEVELS * IDX_W,
  localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int unsigned PFN_W  = PA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PA_W-1:0]    root_base_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  output logic               busy_o,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [PA_W-1:0]    rsp_paddr_o,
  output logic [1:0]         rsp_perm_o,
  output logic               rsp_fault_o,
  output logic [LVL_W-1:0]   rsp_level_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [PA_W-1:0]    mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  output logic               mem_rsp_ready_o,
  input  logic [ENTRY_W-1:0] mem_rsp_data_i
);
  import ptw_pkg::*;

  walk_state_e      state_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  paddr_q;
  logic [1:0]       perm_q;
  logic             fault_q;
  logic [LVL_W-1:0] flvl_q;

  logic             pte_present;
  logic             pte_wr;
  logic             pte_usr;
  logic [PFN_W-1:0] pte_pfn;

  ptw_idx_addr #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .ENTRY_W(ENTRY_W)
  ) u_idx (
    .vaddr      (vaddr_q),
    .lvl        (lvl_q),
    .dir_base   (base_q),
    .entry_addr (mem_req_addr_o)
  );

  ptw_pte_decode #(
    .ENTRY_W(ENTRY_W), .PA_W(PA_W), .OFF_W(OFF_W)
  ) u_dec (
    .entry   (mem_rsp_data_i),
    .present (pte_present),
    .wr_ok   (pte_wr),
    .usr_ok  (pte_usr),
    .pfn     (pte_pfn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      vaddr_q <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      paddr_q <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          if (req_valid_i) begin
            vaddr_q <= req_vaddr_i;
            base_q  <= root_base_i;
            lvl_q   <= LVL_W'(LEVELS - 1);
            state_q <= WK_ISSUE;
          end
        end
        WK_ISSUE: begin
          if (mem_req_ready_i) state_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (mem_rsp_valid_i) begin
            if (!pte_present) begin
              fault_q <= 1'b1;
              flvl_q  <= lvl_q;
              paddr_q <= '0;
              perm_q  <= '0;
              state_q <= WK_RESP;
            end else if (lvl_q == '0) begin
              fault_q <= 1'b0;
              flvl_q  <= '0;
              paddr_q <= {pte_pfn, vaddr_q[OFF_W-1:0]};
              perm_q  <= {pte_usr, pte_wr};
              state_q <= WK_RESP;
            end else begin
              base_q  <= {pte_pfn, {OFF_W{1'b0}}};
              lvl_q   <= lvl_q - LVL_W'(1);
              state_q <= WK_ISSUE;
            end
          end
        end
        WK_RESP: begin
          if (rsp_ready_i) state_q <= WK_IDLE;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == WK_IDLE);
  assign busy_o          = (state_q != WK_IDLE);
  assign mem_req_valid_o = (state_q == WK_ISSUE);
  assign mem_rsp_ready_o = (state_q == WK_WAIT);
  assign rsp_valid_o     = (state_q == WK_RESP);
  assign rsp_paddr_o     = paddr_q;
  assign rsp_perm_o      = perm_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_level_o     = flvl_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned PA_W  = 52,
  parameter int unsigned LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             busy_o,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic [1:0]       rsp_perm_o,
  input logic             rsp_fault_o,
  input logic [LVL_W-1:0] rsp_level_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic             mem_rsp_ready_o
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_ready_o |=> busy_o && !req_ready_o);

  // R4
  serial_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid_o, mem_rsp_ready_o, rsp_valid_o}));

  // R8
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=>
      rsp_valid_o && $stable({rsp_paddr_o, rsp_perm_o, rsp_fault_o, rsp_level_o}));

  // R7
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0 && rsp_perm_o == '0);

  // R6
  ok_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_fault_o |-> rsp_level_o == '0);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .LVL_W(LVL_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .busy_o          (busy_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_paddr_o     (rsp_paddr_o),
  .rsp_perm_o      (rsp_perm_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_level_o     (rsp_level_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_ready_o (mem_rsp_ready_o)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [51:0] root_base_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [47:0] req_vaddr_i;
  logic        busy_o;
  logic        rsp_valid_o;
  logic        rsp_ready_i;
  logic [51:0] rsp_paddr_o;
  logic [1:0]  rsp_perm_o;
  logic        rsp_fault_o;
  logic [1:0]  rsp_level_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i;
  logic [51:0] mem_req_addr_o;
  logic        mem_rsp_valid_i;
  logic        mem_rsp_ready_o;
  logic [63:0] mem_rsp_data_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .root_base_i(root_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
    .busy_o(busy_o), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_paddr_o(rsp_paddr_o), .rsp_perm_o(rsp_perm_o), .rsp_fault_o(rsp_fault_o),
    .rsp_level_o(rsp_level_o), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_ready_o(mem_rsp_ready_o),
    .mem_rsp_data_i(mem_rsp_data_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] make_pte(input logic [39:0] pfn, input bit p,
                                          input bit w, input bit u);
    // Junk in bits 63:52 and 11:3 must not matter (R5).
    return {12'hA5C, pfn, 9'h16B, u, w, p};
  endfunction

  // fault_lvl: 0 = none, otherwise level 4..1 whose entry is not present.
  task automatic walk(input logic [47:0] va, input int t, input int fault_lvl);
    logic [39:0] pfn [4];
    logic [51:0] exp_addr;
    logic [8:0]  idx;
    bit          w_bit, u_bit, stall, bp, pres, stop;
    int          lat;
    w_bit = t[0];
    u_bit = t[1];
    stall = t[0] ^ t[2];
    bp    = t[1] ^ t[3];
    lat   = t % 3;
    for (int k = 0; k < 4; k++) pfn[k] = 40'h00_0200_0000 + 40'(t * 64 + k * 5 + 1);
    root_base_i = 52'h0_0012_3456_7000 + 52'(t * 4096);

    chk(req_ready_o === 1'b1, "R2", "ready when idle", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    @(negedge clk);
    // Offer a stray request while busy; it must be ignored (R2).
    req_vaddr_i = ~va;
    req_valid_i = 1'b1;
    chk(busy_o === 1'b1 && req_ready_o === 1'b0, "R2", "busy after accept",
        64'({busy_o, req_ready_o}), 64'b10);

    stop = 1'b0;
    for (int k = 3; k >= 0; k--) begin
      if (!stop) begin
        idx = va[12 + 9*k +: 9];
        exp_addr = (k == 3) ? root_base_i : {pfn[k+1], 12'h000};
        exp_addr = exp_addr + 52'({idx, 3'b000});
        chk(mem_req_valid_o === 1'b1, "R11", "read request due", 64'(mem_req_valid_o), 64'd1);
        chk(mem_req_addr_o === exp_addr, (k == 3) ? "R3" : "R4", "entry address",
            64'(mem_req_addr_o), 64'(exp_addr));
        if (stall) begin
          mem_req_ready_i = 1'b0;
          @(negedge clk);
          chk(mem_req_valid_o === 1'b1 && mem_req_addr_o === exp_addr, "R8",
              "request held while stalled", 64'(mem_req_addr_o), 64'(exp_addr));
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        for (int c = 0; c < lat; c++) begin
          chk(mem_rsp_ready_o === 1'b1 && mem_req_valid_o === 1'b0, "R9",
              "waiting for data", 64'({mem_rsp_ready_o, mem_req_valid_o}), 64'b10);
          @(negedge clk);
        end
        chk(mem_rsp_ready_o === 1'b1, "R9", "data accepted", 64'(mem_rsp_ready_o), 64'd1);
        pres = (fault_lvl != k + 1);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = make_pte(pfn[k], pres, w_bit, u_bit);
        if (!pres || k == 0) req_valid_i = 1'b0;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        mem_rsp_data_i  = 64'hFFFF_FFFF_FFFF_FFFF;
        if (!pres) stop = 1'b1;
      end
    end

    chk(rsp_valid_o === 1'b1, "R11", "result due", 64'(rsp_valid_o), 64'd1);
    chk(mem_req_valid_o === 1'b0, "R7", "no read after last", 64'(mem_req_valid_o), 64'd0);
    if (fault_lvl == 0) begin
      chk(rsp_fault_o === 1'b0 && rsp_level_o === 2'd0, "R6", "no fault",
          64'({rsp_fault_o, rsp_level_o}), 64'd0);
      chk(rsp_paddr_o === {pfn[0], va[11:0]}, "R6", "physical address",
          64'(rsp_paddr_o), 64'({pfn[0], va[11:0]}));
      chk(rsp_perm_o === {u_bit, w_bit}, "R6", "permissions",
          64'(rsp_perm_o), 64'({u_bit, w_bit}));
    end else begin
      chk(rsp_fault_o === 1'b1 && rsp_level_o === 2'(fault_lvl - 1), "R7", "fault level",
          64'({rsp_fault_o, rsp_level_o}), 64'({1'b1, 2'(fault_lvl - 1)}));
      chk(rsp_paddr_o === '0 && rsp_perm_o === '0, "R7", "fault clears result",
          64'(rsp_paddr_o), 64'd0);
    end
    if (bp) begin
      rsp_ready_i = 1'b0;
      @(negedge clk);
      chk(rsp_valid_o === 1'b1, "R10", "result held", 64'(rsp_valid_o), 64'd1);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    chk(busy_o === 1'b0 && rsp_valid_o === 1'b0 && req_ready_o === 1'b1, "R2",
        "idle after response", 64'({busy_o, rsp_valid_o, req_ready_o}), 64'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] lcg;
    logic [47:0] va;
    int t;
    rst_n = 1'b0;
    root_base_i = '0;
    req_valid_i = 1'b0;
    req_vaddr_i = '0;
    rsp_ready_i = 1'b0;
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy_o === 1'b0 && req_ready_o === 1'b1 && mem_req_valid_o === 1'b0 &&
        rsp_valid_o === 1'b0, "R1", "reset state",
        64'({busy_o, req_ready_o, mem_req_valid_o, rsp_valid_o}), 64'b0100);

    lcg = 64'h0123_4567_89AB_CDEF;
    t = 0;
    for (int v = 0; v < 15; v++) begin
      if (v == 0)      va = 48'h0;
      else if (v == 1) va = 48'hFFFF_FFFF_FFFF;
      else if (v == 2) va = {9'd511, 9'd0, 9'd256, 9'd1, 12'hABC};
      else begin
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        va  = lcg[59:12];
      end
      for (int f = 0; f <= 4; f++) begin
        walk(va, t, f);
        t++;
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule